// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs Clause 22 read and write frames towards an external PHY. Software sees two 16-bit registers: a control word and a data word. The control word packs the PHY address, the PHY register number, a clock-range code, a direction flag and a busy flag. Writing it with busy set launches a frame. When busy drops, a completed read leaves the PHY's 16-bit answer in the data word. A write frame sends whatever the data word held when the command was given.

The management clock is produced from the system clock by a divider. The clock-range code chosen in the command picks the divide ratio. The serial line is driven through separate output and output-enable pins, and its input is sampled on its own pin. A control write with the busy bit clear, such as all zeros, does not start a frame. It still emits one management-clock period, which lets a PHY whose reset only completes after seeing a clock finish that reset.

Top module: `mdio_master`

## Requirements
- R1: The control word layout is: bit 0 busy, bit 1 direction (1 = write, 0 = read), bits 5:2 clock-range code, bits 10:6 PHY register number, bits 15:11 PHY address. A control write with bit 0 set while idle starts a frame, and the written word reads back on `ctrl_rdata` with bit 0 high.
- R2: Hardware clears the busy bit when a frame ends, and leaves the other control bits unchanged.
- R3: A write frame is, MSB first: 32 ones, start `01`, opcode `01`, 5-bit PHY address, 5-bit register number, turnaround `10`, then the 16 data-word bits. All 64 bits are driven with output enable high.
- R4: A read frame uses opcode `10` and the same 46-bit header. The output enable is low from the turnaround (bit 46) to the end of the frame.
- R5: In a read, the 16 bits sampled at management-clock rising edges 48..63 (MSB first) appear on `data_rdata` once busy has cleared.
- R6: The management clock period in system clocks is 42, 62, 16, 26, 102 or 124 for codes 0 to 5. Every other code gives 124. The management clock is low whenever no frame or dummy access is running.
- R7: The serial output changes only together with a falling management-clock edge, so it is stable while the clock is high. It is sampled on the rising edge.
- R8: While busy is 1, writes to either register are ignored. The running frame and the readable control fields are unaffected.
- R9: A control write with bit 0 clear while idle produces exactly one management-clock period. During it the output enable stays low and busy stays 0.
- R10: A synchronous reset clears both registers, holds the management clock low and deasserts the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 data word |
| reg_wdata | input | 16 | Register write data |
| ctrl_rdata | output | 16 | Current control word, including the live busy bit |
| data_rdata | output | 16 | Current data word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data output |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data input |

## Verification
A bit counter or shift register that falls out of step shows up within one frame. The 64 bits captured at the rising edges then differ from the expected frame, or the output enable drops at the wrong bit. The same fault can also leave busy stuck high, which the completion wait catches. A divider fault shows on the very next management-clock period, whose length is compared with the table for each code. Faults in read capture or in command blocking show only when the frame completes, as a wrong data word or a changed control field.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [3:0] crange;
    logic       wr;
    logic       busy;
  } ctrl_t;

  function automatic logic [7:0] mdc_ratio(input logic [3:0] code);
    logic [7:0] r;
    case (code)
      4'd0:    r = 8'd42;
      4'd1:    r = 8'd62;
      4'd2:    r = 8'd16;
      4'd3:    r = 8'd26;
      4'd4:    r = 8'd102;
      default: r = 8'd124;
    endcase
    return r;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input ctrl_t c,
                                                        input logic [15:0] d);
    logic [1:0] op;
    op = c.wr ? 2'b01 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, 2'b10, d};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] ratio,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  assign half = ratio >> 1;

  always_comb begin
    rise_stb = en && (cnt == half - 1'b1);
    fall_stb = en && (cnt == ratio - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_stb) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_stb) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_read,
  input  logic [NBITS-1:0] frame_in,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [15:0]      rd_data,
  output logic             done
);
  localparam int RC_W = $clog2(NBITS + 1);

  logic [NBITS-1:0] sreg;
  logic [RC_W-1:0]  rc;
  logic             active;
  logic             rd_q;

  assign mdio_o = sreg[NBITS-1];
  assign done   = active && fall_stb && (rc == RC_W'(NBITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      rc      <= '0;
      active  <= 1'b0;
      rd_q    <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      sreg    <= frame_in;
      rc      <= '0;
      active  <= 1'b1;
      rd_q    <= is_read;
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (rise_stb) begin
        rc <= rc + 1'b1;
        if (rd_q && rc >= RC_W'(DATA_POS))
          rd_data <= {rd_data[14:0], mdio_i};
      end
      if (fall_stb) begin
        if (rc == RC_W'(NBITS)) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          sreg <= sreg << 1;
          if (rd_q && rc >= RC_W'(TA_POS)) mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  ctrl_t       ctrl_q;
  logic [15:0] data_q;
  logic        dummy_q;
  logic        idle;
  logic        ctrl_wr;
  logic        data_wr;
  logic        start;
  logic        clk_en;
  logic        rise_stb;
  logic        fall_stb;
  logic        frame_done;
  logic [15:0] rd_data_w;
  logic [CNT_W-1:0] ratio;
  ctrl_t       wr_word;

  assign wr_word    = ctrl_t'(reg_wdata);
  assign idle       = !ctrl_q.busy && !dummy_q;
  assign ctrl_wr    = reg_wr_en && !reg_sel;
  assign data_wr    = reg_wr_en && reg_sel;
  assign start      = ctrl_wr && idle && wr_word.busy;
  assign clk_en     = ctrl_q.busy || dummy_q;
  assign ratio      = CNT_W'(mdc_ratio(ctrl_q.crange));
  assign ctrl_rdata = 16'(ctrl_q);
  assign data_rdata = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      dummy_q <= 1'b0;
    end else begin
      if (ctrl_wr && idle) begin
        ctrl_q  <= wr_word;
        dummy_q <= !wr_word.busy;
      end
      if (data_wr && idle) data_q <= reg_wdata;
      if (frame_done) begin
        ctrl_q.busy <= 1'b0;
        if (!ctrl_q.wr) data_q <= rd_data_w;
      end
      if (dummy_q && fall_stb) dummy_q <= 1'b0;
    end
  end

  mdio_clkgen #(.CNT_W(CNT_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .ratio    (ratio),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame #(.NBITS(FRAME_BITS)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .is_read  (!wr_word.wr),
    .frame_in (build_frame(wr_word, data_q)),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data_w),
    .done     (frame_done)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] ctrl_rdata,
  input logic        clk_en,
  input logic        frame_done,
  input logic        dummy_on
);
  assert_out_stable_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  assert_idle_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rdata[0] |-> !mdio_oe);

  assert_dummy_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    dummy_on |-> (!mdio_oe && !ctrl_rdata[0]));

  assert_done_clears_busy_R2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !ctrl_rdata[0]);

  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata[0] && $past(ctrl_rdata[0])) |-> $stable(ctrl_rdata[15:1]));

  assert_release_only_read_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata[0] && $fell(mdio_oe)) |-> !ctrl_rdata[1]);

  assert_mdc_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !$past(clk_en)) |-> !mdc);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .ctrl_rdata (ctrl_rdata),
  .clk_en     (clk_en),
  .frame_done (frame_done),
  .dummy_on   (dummy_q)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    bit          rd;
    logic [63:0] f;
    logic [15:0] v;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   tests = 0;
  int   fails = 0;
  int   k = 0;
  int   cyc = 0;
  int   rises = 0;
  int   last_rise = 0;
  int   period = 0;
  bit   oe_seen = 0;
  logic [63:0] got;
  int   oe_bad;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mdio_oe) oe_seen <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(input int code);
    int tbl[6] = '{42, 62, 16, 26, 102, 124};
    return (code < 6) ? tbl[code] : 124;
  endfunction

  function automatic logic [15:0] cmd(input int phy, input int rg,
                                      input int cr, input bit wr);
    return 16'((phy << 11) | (rg << 6) | (cr << 2) | (int'(wr) << 1) | 1);
  endfunction

  // Scoreboard monitor: acts as the PHY, captures frames at MDC rising edges
  always @(posedge mdc) begin
    rises++;
    period    = cyc - last_rise;
    last_rise = cyc;
    if (ctrl_rdata[0]) begin
      if (k == 0) begin
        oe_bad = 0;
        if (q.size() == 0) begin
          check(1'b0, "R3", "frame with empty scoreboard", 0, 1);
          cur = '{rd: 1'b0, f: '0, v: '0};
        end else begin
          cur = q.pop_front();
        end
      end
      got = {got[62:0], mdio_o};
      if (mdio_oe !== !(cur.rd && k >= 46)) oe_bad++;
      k++;
      if (k == 64) begin
        if (cur.rd) begin
          check(got[63:18] == cur.f[63:18], "R4", "read header bits",
                64'(got[63:18]), 64'(cur.f[63:18]));
          check(oe_bad == 0, "R4", "output enable pattern", oe_bad, 0);
        end else begin
          check(got == cur.f, "R3", "write frame bits", got, cur.f);
          check(oe_bad == 0, "R3", "output enable held", oe_bad, 0);
        end
        k = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (ctrl_rdata[0] && cur.rd && k >= 48 && k < 64)
      mdio_i = cur.v[63 - k];
    else
      mdio_i = 1'b1;
  end

  task automatic reg_write(input bit sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (ctrl_rdata[0] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(ctrl_rdata[0] == 1'b0, req, "busy cleared", ctrl_rdata[0], 0);
  endtask

  task automatic do_write(input int phy, input int rg, input int cr,
                          input logic [15:0] d);
    logic [15:0] c;
    c = cmd(phy, rg, cr, 1'b1);
    q.push_back('{rd: 1'b0,
                  f: {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(phy), 5'(rg), 2'b10, d},
                  v: '0});
    reg_write(1'b1, d);
    reg_write(1'b0, c);
    check(ctrl_rdata == c, "R1", "control readback while busy", ctrl_rdata, c);
    wait_idle("R2");
    check(ctrl_rdata == (c & 16'hFFFE), "R2", "fields kept after done",
          ctrl_rdata, c & 16'hFFFE);
    check(period == exp_period(cr), "R6", "mdc period", period, exp_period(cr));
  endtask

  task automatic do_read(input int phy, input int rg, input int cr,
                         input logic [15:0] v);
    q.push_back('{rd: 1'b1,
                  f: {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(phy), 5'(rg), 18'h0},
                  v: v});
    reg_write(1'b0, cmd(phy, rg, cr, 1'b0));
    wait_idle("R2");
    check(data_rdata == v, "R5", "read data captured", data_rdata, v);
    check(period == exp_period(cr), "R6", "mdc period", period, exp_period(cr));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(ctrl_rdata == 0 && data_rdata == 0, "R10", "registers after reset",
          {ctrl_rdata, data_rdata}, 0);
    check(mdc == 0 && mdio_oe == 0, "R10", "mdc and oe after reset",
          {mdc, mdio_oe}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    do_write(5'h13, 5'h04, 2, 16'hA5C3);
    do_write(5'h00, 5'h1F, 3, 16'h0001);
    do_read(5'h1F, 5'h02, 2, 16'h8E71);
    do_read(5'h01, 5'h10, 0, 16'h7F00);
    do_read(5'h0A, 5'h15, 9, 16'hC35A); // R6 fallback code

    // R8: writes while busy are ignored
    begin
      logic [15:0] c0;
      c0 = cmd(5'h06, 5'h03, 2, 1'b1);
      q.push_back('{rd: 1'b0,
                    f: {32'hFFFF_FFFF, 4'b0101, 5'h06, 5'h03, 2'b10, 16'h1234},
                    v: '0});
      reg_write(1'b1, 16'h1234);
      reg_write(1'b0, c0);
      repeat (300) @(negedge clk);
      reg_write(1'b0, cmd(5'h19, 5'h0E, 4, 1'b0));
      reg_write(1'b1, 16'hBEEF);
      check(ctrl_rdata == c0, "R8", "control unchanged mid-frame", ctrl_rdata, c0);
      wait_idle("R8");
      check(data_rdata == 16'h1234, "R8", "data word unchanged", data_rdata, 16'h1234);
      check(q.size() == 0, "R8", "no extra frame queued", q.size(), 0);
    end

    // R9: dummy access, one MDC period, no drive
    begin
      int r0;
      repeat (20) @(negedge clk);
      r0 = rises;
      oe_seen = 1'b0;
      reg_write(1'b0, 16'h0000);
      repeat (200) @(negedge clk);
      check(rises - r0 == 1, "R9", "mdc pulses on dummy", rises - r0, 1);
      check(oe_seen == 1'b0, "R9", "oe during dummy", oe_seen, 0);
      check(ctrl_rdata == 0, "R9", "busy stays clear", ctrl_rdata, 0);
      check(mdc == 1'b0, "R6", "mdc low when idle", mdc, 0);
    end

    check(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule